// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a virtual address into a physical address through a small table of segments. The upper bits of the virtual address pick one table entry. The remaining lower bits are the offset inside that segment. Each entry holds a base and a size. When the offset is below the size, the result is the base plus the offset. Otherwise the block reports a fault and drives a zeroed address.

A request is presented with a valid strobe. The result appears one clock later on a registered output. An entry whose size is zero is an unmapped hole, so every access to it faults. The table comes out of reset with a fixed four-entry layout: code, data, a hole, and stack. The table is reloaded through a write port that only acts when the writer asserts supervisor mode.

The block sits beside a load/store path. The write port is driven by privileged control logic.

Top module: `seg_translator`

## Requirements
- R1: After a synchronous active-low reset, `xl_valid`, `xl_fault` and `xl_paddr` are 0, and the table holds these entries:
  - index 0: base 0x4000, size 0x700
  - index 1: base 0x0000, size 0x500
  - index 2: base 0, size 0
  - index 3: base 0x2000, size 0x1000
- R2: Bits [15:14] of `va_addr` select the table index, and bits [13:0] form the offset.
- R3: When a request is accepted with offset < size, `xl_valid` is 1 one clock later, `xl_fault` is 0, and `xl_paddr` equals base + offset.
- R4: When a request is accepted with offset >= size, `xl_valid` and `xl_fault` are 1 one clock later, and `xl_paddr` is 0.
- R5: An entry with size 0 faults for every offset, including offset 0.
- R6: A write with `tw_en` = 1 and `tw_super` = 1 replaces entry `tw_index`. A translation accepted on the same clock edge still uses the old entry. Translations accepted from the next edge on use the new entry.
- R7: A write with `tw_super` = 0 is ignored, and later translations still use the previous entry contents.
- R8: A clock edge with `va_valid` = 0 gives `xl_valid` = 0, `xl_fault` = 0 and `xl_paddr` = 0 one clock later.
- R9: The sum base + offset wraps modulo 2^16 on `xl_paddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| va_valid | input | 1 | Translation request strobe |
| va_addr | input | 16 | Virtual address: index in [15:14], offset in [13:0] |
| tw_en | input | 1 | Table write request |
| tw_super | input | 1 | Writer is in supervisor mode |
| tw_index | input | 2 | Entry to write |
| tw_base | input | 16 | New segment base |
| tw_size | input | 15 | New segment size (bound) |
| xl_valid | output | 1 | Result valid, one clock after the request |
| xl_fault | output | 1 | Offset not below segment size |
| xl_paddr | output | 16 | Physical address, 0 when faulting or idle |

## Verification
The assertions assume one thing about the inputs: the write fields and the request address settle away from the clock edge and may change freely from one cycle to the next. Only the reset and the two strobes are treated as qualifiers. No handshake between the write port and the request port is assumed, so the stimulus deliberately issues a supervisor write and a translation on the same edge.

The stimulus sweeps every virtual address of the default table. It then reloads entries with sizes and bases chosen to land exactly on the bound and on the wrap point. Unprivileged writes are interleaved, and the bench expects them to leave no trace.

// File: rtl/seg_xlate_pkg.sv
// Package: shared constants and reset-time table layout for the segment
// translator. Assumes at most four default entries; others reset to zero.
package seg_xlate_pkg;

    // Reset base for a given entry index.
    function automatic logic [31:0] dflt_base(input int idx);
        case (idx)
            0:       return 32'h4000;
            1:       return 32'h0000;
            3:       return 32'h2000;
            default: return 32'h0;
        endcase
    endfunction

    // Reset size for a given entry index; zero marks an unmapped hole.
    function automatic logic [31:0] dflt_size(input int idx);
        case (idx)
            0:       return 32'h0700;
            1:       return 32'h0500;
            3:       return 32'h1000;
            default: return 32'h0;
        endcase
    endfunction

endpackage

// File: rtl/seg_table.sv
// Module: segment table storage with a privileged write port and one
// combinational read port. Assumes writes without supervisor mode must be
// dropped silently; a write lands on the clock edge, so reads in the same
// cycle see the previous contents.
module seg_table
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W  = 2,
    parameter int BASE_W = 16,
    parameter int SIZE_W = 15,
    localparam int N_SEG = 1 << SEG_W,
    localparam int ENT_W = BASE_W + SIZE_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   wr_super,
    input  logic [SEG_W-1:0]       wr_idx,
    input  logic [BASE_W-1:0]      wr_base,
    input  logic [SIZE_W-1:0]      wr_size,
    input  logic [SEG_W-1:0]       rd_idx,
    output logic [BASE_W-1:0]      rd_base,
    output logic [SIZE_W-1:0]      rd_size,
    output logic [N_SEG*ENT_W-1:0] tbl_flat
);

    logic [BASE_W-1:0] base_q [N_SEG];
    logic [SIZE_W-1:0] size_q [N_SEG];
    logic              wr_ok;

    // Gate the write strobe with privilege.
    always_comb wr_ok = wr_en && wr_super;

    for (genvar g = 0; g < N_SEG; g++) begin : g_ent
        // Hold one entry: reset layout, then privileged writes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[g] <= BASE_W'(dflt_base(g));
                size_q[g] <= SIZE_W'(dflt_size(g));
            end else if (wr_ok && (wr_idx == SEG_W'(g))) begin
                base_q[g] <= wr_base;
                size_q[g] <= wr_size;
            end
        end

        // Expose the entry for observation.
        always_comb tbl_flat[g*ENT_W +: ENT_W] = {base_q[g], size_q[g]};
    end

    // Select the addressed entry.
    always_comb begin
        rd_base = base_q[rd_idx];
        rd_size = size_q[rd_idx];
    end

endmodule

// File: rtl/seg_bound_check.sv
// Module: bound check and relocation for one offset against one entry.
// Purely combinational. Assumes PA_W >= OFF_W and SIZE_W = OFF_W + 1, so
// any offset can be compared against any size without truncation.
module seg_bound_check #(
    parameter int OFF_W  = 14,
    parameter int PA_W   = 16,
    parameter int SIZE_W = 15
) (
    input  logic [OFF_W-1:0]  offset,
    input  logic [PA_W-1:0]   base,
    input  logic [SIZE_W-1:0] size,
    output logic              over,
    output logic [PA_W-1:0]   paddr
);

    // Compare the widened offset with the bound; a zero size always trips.
    always_comb over = (SIZE_W'(offset) >= size);

    // Relocate: base plus offset, wrapping at the physical width.
    always_comb paddr = over ? '0 : (base + PA_W'(offset));

endmodule

// File: rtl/seg_translator.sv
// Module: top of the segment-table translator. Splits the virtual address
// into index and offset, looks the entry up, checks the bound and registers
// the result for one cycle. Assumes requests need no back-pressure.
module seg_translator #(
    parameter int VA_W   = 16,
    parameter int SEG_W  = 2,
    parameter int PA_W   = 16,
    localparam int OFF_W  = VA_W - SEG_W,
    localparam int SIZE_W = OFF_W + 1,
    localparam int N_SEG  = 1 << SEG_W,
    localparam int ENT_W  = PA_W + SIZE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              va_valid,
    input  logic [VA_W-1:0]   va_addr,
    input  logic              tw_en,
    input  logic              tw_super,
    input  logic [SEG_W-1:0]  tw_index,
    input  logic [PA_W-1:0]   tw_base,
    input  logic [SIZE_W-1:0] tw_size,
    output logic              xl_valid,
    output logic              xl_fault,
    output logic [PA_W-1:0]   xl_paddr
);

    logic [SEG_W-1:0]       seg_idx;
    logic [OFF_W-1:0]       seg_off;
    logic [PA_W-1:0]        sel_base;
    logic [SIZE_W-1:0]      sel_size;
    logic [N_SEG*ENT_W-1:0] tbl_flat;
    logic                   over;
    logic [PA_W-1:0]        reloc;

    // Split the virtual address into index and offset.
    always_comb begin
        seg_idx = va_addr[VA_W-1 -: SEG_W];
        seg_off = va_addr[OFF_W-1:0];
    end

    seg_table #(
        .SEG_W  (SEG_W),
        .BASE_W (PA_W),
        .SIZE_W (SIZE_W)
    ) i_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tw_en),
        .wr_super (tw_super),
        .wr_idx   (tw_index),
        .wr_base  (tw_base),
        .wr_size  (tw_size),
        .rd_idx   (seg_idx),
        .rd_base  (sel_base),
        .rd_size  (sel_size),
        .tbl_flat (tbl_flat)
    );

    seg_bound_check #(
        .OFF_W  (OFF_W),
        .PA_W   (PA_W),
        .SIZE_W (SIZE_W)
    ) i_check (
        .offset (seg_off),
        .base   (sel_base),
        .size   (sel_size),
        .over   (over),
        .paddr  (reloc)
    );

    // Register the result; idle cycles clear all outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xl_valid <= 1'b0;
            xl_fault <= 1'b0;
            xl_paddr <= '0;
        end else begin
            xl_valid <= va_valid;
            xl_fault <= va_valid && over;
            xl_paddr <= va_valid ? reloc : '0;
        end
    end

endmodule

// File: rtl/seg_translator_chk.sv
// Module: assertion checker for seg_translator, attached by bind.
// Observes ports plus the table read and flat table image.
module seg_translator_chk #(
    parameter int PA_W   = 16,
    parameter int SIZE_W = 15,
    parameter int TBL_W  = 124
) (
    input logic              clk,
    input logic              rst_n,
    input logic              va_valid,
    input logic              tw_en,
    input logic              tw_super,
    input logic              xl_valid,
    input logic              xl_fault,
    input logic [PA_W-1:0]   xl_paddr,
    input logic [SIZE_W-1:0] sel_size,
    input logic [TBL_W-1:0]  tbl_flat
);

    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        va_valid |=> xl_valid); // R3

    AST_FAULT_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
        xl_fault |-> (xl_valid && xl_paddr == '0)); // R4

    AST_HOLE_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (va_valid && sel_size == '0) |=> xl_fault); // R5

    AST_USER_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !(tw_en && tw_super) |=> $stable(tbl_flat)); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !va_valid |=> (!xl_valid && !xl_fault && xl_paddr == '0)); // R8

endmodule

bind seg_translator seg_translator_chk #(
    .PA_W   (PA_W),
    .SIZE_W (SIZE_W),
    .TBL_W  (N_SEG*ENT_W)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .va_valid (va_valid),
    .tw_en    (tw_en),
    .tw_super (tw_super),
    .xl_valid (xl_valid),
    .xl_fault (xl_fault),
    .xl_paddr (xl_paddr),
    .sel_size (sel_size),
    .tbl_flat (tbl_flat)
);

// File: tb/test_seg_translator.sv
`timescale 1ns/1ps
module test_seg_translator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        va_valid = 1'b0;
    logic [15:0] va_addr = '0;
    logic        tw_en = 1'b0;
    logic        tw_super = 1'b0;
    logic [1:0]  tw_index = '0;
    logic [15:0] tw_base = '0;
    logic [14:0] tw_size = '0;
    logic        xl_valid;
    logic        xl_fault;
    logic [15:0] xl_paddr;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 0;
    int mb [4];
    int ms [4];

    always #4 clk = ~clk;

    seg_translator i_seg_translator (
        .clk(clk), .rst_n(rst_n), .va_valid(va_valid), .va_addr(va_addr),
        .tw_en(tw_en), .tw_super(tw_super), .tw_index(tw_index),
        .tw_base(tw_base), .tw_size(tw_size), .xl_valid(xl_valid),
        .xl_fault(xl_fault), .xl_paddr(xl_paddr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Drive one request now (just after a negedge); check at the next negedge.
    task automatic xl(input int va, input string tag);
        int s = (va >> 14) & 3;
        int o = va & 16'h3FFF;
        bit f = (o >= ms[s]);
        int ep = f ? 0 : ((mb[s] + o) & 16'hFFFF);
        va_valid = 1'b1;
        va_addr  = 16'(va);
        @(negedge clk);
        chk({tag, " valid"}, int'(xl_valid), 1);
        chk({tag, " fault"}, int'(xl_fault), int'(f));
        chk({tag, " paddr"}, int'(xl_paddr), ep);
    endtask

    // Issue a table write lasting one edge; the model follows only if privileged.
    task automatic wr(input int idx, input int b, input int sz, input bit sup);
        tw_en = 1'b1; tw_super = sup; tw_index = 2'(idx);
        tw_base = 16'(b); tw_size = 15'(sz);
        va_valid = 1'b0;
        @(negedge clk);
        tw_en = 1'b0; tw_super = 1'b0;
        if (sup) begin mb[idx] = b; ms[idx] = sz; end
    endtask

    function automatic string sweep_tag(input int va);
        int s = (va >> 14) & 3;
        int o = va & 16'h3FFF;
        if (ms[s] == 0) return "R5 R2";
        if (o >= ms[s]) return "R4 R2";
        return "R3 R2";
    endfunction

    initial begin
        mb[0] = 16'h4000; ms[0] = 16'h0700;
        mb[1] = 16'h0000; ms[1] = 16'h0500;
        mb[2] = 0;        ms[2] = 0;
        mb[3] = 16'h2000; ms[3] = 16'h1000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: outputs cleared straight after reset.
        chk("R1 valid", int'(xl_valid), 0);
        chk("R1 fault", int'(xl_fault), 0);
        chk("R1 paddr", int'(xl_paddr), 0);
        // R1: default table, spot entries and bounds.
        xl(16'h0000, "R1 code base");
        xl(16'h06FF, "R1 code last");
        xl(16'h0700, "R1 code bound");
        xl(16'h44FF, "R1 data last");
        xl(16'hC0FF, "R1 stack");
        xl(16'h8000, "R1 R5 hole off0");
        // R2..R5: full sweep of every virtual address on the reset table.
        for (int va = 0; va < 65536; va++) xl(va, sweep_tag(va));
        // R8: idle edge with a live-looking address.
        va_valid = 1'b0; va_addr = 16'h0100;
        @(negedge clk);
        chk("R8 valid", int'(xl_valid), 0);
        chk("R8 fault", int'(xl_fault), 0);
        chk("R8 paddr", int'(xl_paddr), 0);
        // R7: unprivileged write to entry 0 leaves old bound in force.
        wr(0, 16'h1111, 16'h0010, 1'b0);
        xl(16'h0010, "R7 old entry kept");
        xl(16'h06FF, "R7 old bound kept");
        // R6: privileged write and translation on the same edge use the old entry.
        tw_en = 1'b1; tw_super = 1'b1; tw_index = 2'd0;
        tw_base = 16'h1000; tw_size = 15'h0020;
        xl(16'h0100, "R6 same-edge old");
        tw_en = 1'b0; tw_super = 1'b0;
        mb[0] = 16'h1000; ms[0] = 16'h0020;
        xl(16'h0100, "R6 next new bound");
        xl(16'h001F, "R6 next new base");
        // R6/R5: map the hole, then punch entry 1 into a hole.
        wr(2, 16'h7000, 16'h0001, 1'b1);
        xl(16'h8000, "R6 hole mapped");
        xl(16'h8001, "R6 hole bound");
        wr(1, 16'h3000, 0, 1'b1);
        xl(16'h4000, "R5 new hole");
        // R9: wrap of base plus offset; R4 at full-size bound.
        wr(3, 16'hFF00, 15'h4000, 1'b1);
        xl(16'hC200, "R9 wrap");
        xl(16'hFFFF, "R9 top offset");
        // R2..R9 stride sweep over the reloaded table.
        for (int va = 0; va < 65536; va += 7) xl(va, sweep_tag(va));
        va_valid = 1'b0;
        @(negedge clk);
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!ended) begin
            ended = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule